// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block is the operating-mode state machine of a CAN node. It holds the mode-control bits that software writes (reset request, halt request, sleep, and three enables that govern bus-off handling and wake-up). From these bits and from four status lines of the protocol engine (transmitter busy, receiver busy, bus-off, dominant level seen on the bus) it decides which mode the node is in. It reports the mode, a halt status flag and a reset status flag, and it drives the transmit and receive enables of the protocol engine.

The states are: `ST_RESET` (configuration, engine off), `ST_NORMAL` (transmit and receive), `ST_HALT_REQ` (halt asked for, current traffic may finish), `ST_WAKE_HALT` (halt asked for on wake-up, engine kept off), `ST_HALT` (engine off, halt flag set) and `ST_SLEEP` (engine off, low power). The transitions are: reset release (`ST_RESET` to `ST_NORMAL` when the reset request bit is 0), halt request (`ST_NORMAL` to `ST_HALT_REQ`), halt entry (`ST_HALT_REQ` to `ST_HALT` once the bus condition allows), resume (`ST_HALT` to `ST_NORMAL` when the halt request bit is cleared), sleep entry (`ST_HALT` to `ST_SLEEP`), wake to run (`ST_SLEEP` to `ST_NORMAL`), wake to halt (`ST_SLEEP` to `ST_WAKE_HALT` to `ST_HALT`), and forced reset (any state to `ST_RESET` while the reset request bit is 1).

A control write is captured on one rising edge. The state machine acts on the stored bits at the next rising edge, so a write shows its effect on the mode outputs two edges after the write is presented.

Top module: `can_mode_seq`

## Requirements
- R1: After power-on reset, mode reads 0 (reset), the reset flag is 1, the halt flag is 0 and both engine enables are 0. Mode codes: 0 reset, 1 normal, 2 halt request, 3 halt, 4 sleep.
- R2: Writing the reset request bit as 0 while in reset moves the mode to 1 on the second edge after the write. The reset flag is then 0 and both enables are 1.
- R3: Writing the halt request bit as 1 in normal mode moves the mode to 2 on the second edge after the write, with both enables still 1.
- R4: With the halt-in-bus-off enable at 0, the halt request state moves to halt only when transmitter busy, receiver busy and bus-off are all 0.
- R5: With the halt-in-bus-off enable at 1, the halt request state moves to halt when bus-off is 1, or when transmitter busy and receiver busy are both 0.
- R6: In halt mode (3) the halt flag is 1 and both enables are 0.
- R7: A write that clears the halt request bit while in mode 2 is ignored: the block stays in mode 2 and later enters halt.
- R8: A write that clears the halt request bit, with sleep 0, while in halt returns the mode to 1, and the halt flag falls in the same cycle.
- R9: Sleep (mode 4) is entered only from halt, by one write with the halt request bit 0 and the sleep bit 1. A sleep write in normal mode, or one in halt that keeps the halt request bit at 1, leaves the mode unchanged.
- R10: In sleep, a write with sleep 0 and halt request 0 returns to mode 1. With the auto-wake enable at 1, a dominant bus level also returns to mode 1. With auto-wake at 0, a dominant level has no effect.
- R11: In sleep, a write with sleep 0 and halt request 1 gives mode 2 with both enables 0 for one cycle. The mode is then 3, whatever the busy and bus-off inputs are.
- R12: A rising bus-off in normal mode sets the halt request bit when the auto-halt enable and the halt-in-bus-off enable are both 1. Halt is reached on the third edge after the rise. With either enable at 0, no halt request is made.
- R13: A write with the reset request bit 1 forces mode 0 and the reset flag 1 from any state, and clears the halt request and sleep bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_rst_req | input | 1 | Written reset request bit |
| ctrl_halt_req | input | 1 | Written halt request bit |
| ctrl_sleep | input | 1 | Written sleep bit |
| ctrl_halt_boff | input | 1 | Written halt-in-bus-off enable |
| ctrl_auto_wake | input | 1 | Written auto-wake enable |
| ctrl_auto_halt | input | 1 | Written auto-halt-on-bus-off enable |
| tx_busy | input | 1 | Protocol engine is transmitting |
| rx_busy | input | 1 | Protocol engine is receiving |
| bus_off | input | 1 | Node is bus-off |
| bus_dominant | input | 1 | Dominant level detected on the bus |
| halt_flag | output | 1 | Halt status flag |
| rst_flag | output | 1 | Reset status flag |
| mode | output | 3 | Current mode code |
| tx_en | output | 1 | Transmit enable to protocol engine |
| rx_en | output | 1 | Receive enable to protocol engine |

## Verification
The halt-entry condition is swept over all eight combinations of transmitter busy, receiver busy and bus-off, once with the halt-in-bus-off enable at 0 and once at 1. The bench predicts each halt-or-wait outcome from a formula. This separates the strict idle rule from the bus-off-bypass rule and shows that bus-off alone blocks halt only when the enable is 0. Each blocked case also drops the halt request bit before the bus goes idle, which checks that the drop is ignored. Sleep writes are tried in normal mode, in halt with the halt bit kept at 1, and in halt with the legal combination. Wake-up is tried by software write, by the bus with auto-wake on and off, and into halt while the busy inputs are held high. Bus-off is raised under all four settings of the two bus-off enables, and the reset request is tried from sleep.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        ST_RESET     = 3'd0,
        ST_NORMAL    = 3'd1,
        ST_HALT_REQ  = 3'd2,
        ST_HALT      = 3'd3,
        ST_SLEEP     = 3'd4,
        ST_WAKE_HALT = 3'd5
    } st_e;

    localparam logic [MODE_W-1:0] MODE_RESET    = 3'd0;
    localparam logic [MODE_W-1:0] MODE_NORMAL   = 3'd1;
    localparam logic [MODE_W-1:0] MODE_HALT_REQ = 3'd2;
    localparam logic [MODE_W-1:0] MODE_HALT     = 3'd3;
    localparam logic [MODE_W-1:0] MODE_SLEEP    = 3'd4;

    typedef struct packed {
        logic rst_req;
        logic halt_req;
        logic sleep;
        logic halt_boff;
        logic auto_wake;
        logic auto_halt;
    } ctrl_t;

endpackage

// File: rtl/can_mode_ctrl_reg.sv
module can_mode_ctrl_reg
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  ctrl_t wdata,
    input  st_e   state,
    input  logic  bus_off,
    input  logic  bus_dominant,
    output ctrl_t q
);

    ctrl_t q_nxt;
    logic  boff_q;
    logic  boff_rise;

    assign boff_rise = bus_off && !boff_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '{rst_req: 1'b1, default: 1'b0};
            boff_q <= 1'b0;
        end else begin
            q      <= q_nxt;
            boff_q <= bus_off;
        end
    end

    always_comb begin
        q_nxt = q;
        if (we) begin
            q_nxt.rst_req   = wdata.rst_req;
            q_nxt.halt_boff = wdata.halt_boff;
            q_nxt.auto_wake = wdata.auto_wake;
            q_nxt.auto_halt = wdata.auto_halt;
            if (wdata.rst_req) begin
                q_nxt.halt_req = 1'b0;
                q_nxt.sleep    = 1'b0;
            end else begin
                unique case (state)
                    ST_HALT_REQ, ST_WAKE_HALT: begin
                        // a halt request in flight cannot be withdrawn
                        q_nxt.halt_req = q.halt_req | wdata.halt_req;
                    end
                    ST_HALT: begin
                        q_nxt.halt_req = wdata.halt_req;
                        q_nxt.sleep    = wdata.sleep & ~wdata.halt_req;
                    end
                    ST_SLEEP: begin
                        q_nxt.sleep    = wdata.sleep;
                        q_nxt.halt_req = wdata.sleep ? q.halt_req : wdata.halt_req;
                    end
                    default: begin
                        q_nxt.halt_req = wdata.halt_req;
                        q_nxt.sleep    = 1'b0;
                    end
                endcase
            end
        end else if (state == ST_SLEEP && q.auto_wake && bus_dominant) begin
            q_nxt.sleep = 1'b0;
        end

        if (state == ST_NORMAL && boff_rise && !q_nxt.rst_req
            && q_nxt.auto_halt && q_nxt.halt_boff) begin
            q_nxt.halt_req = 1'b1;
        end
    end

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    input  logic halt_req,
    input  logic sleep,
    input  logic halt_boff,
    input  logic tx_busy,
    input  logic rx_busy,
    input  logic bus_off,
    output st_e  state
);

    st_e  state_nxt;
    logic idle;
    logic halt_ok;

    assign idle    = !tx_busy && !rx_busy;
    assign halt_ok = halt_boff ? (bus_off || idle) : (idle && !bus_off);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RESET;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        if (rst_req) begin
            state_nxt = ST_RESET;
        end else begin
            unique case (state)
                ST_RESET:     state_nxt = ST_NORMAL;
                ST_NORMAL:    if (halt_req) state_nxt = ST_HALT_REQ;
                ST_HALT_REQ:  if (halt_ok) state_nxt = ST_HALT;
                ST_WAKE_HALT: state_nxt = ST_HALT;
                ST_HALT: begin
                    if (sleep)          state_nxt = ST_SLEEP;
                    else if (!halt_req) state_nxt = ST_NORMAL;
                end
                ST_SLEEP: begin
                    if (!sleep) state_nxt = halt_req ? ST_WAKE_HALT : ST_NORMAL;
                end
                default:      state_nxt = ST_RESET;
            endcase
        end
    end

endmodule

// File: rtl/can_mode_out.sv
module can_mode_out
    import can_mode_pkg::*;
(
    input  st_e               state,
    output logic [MODE_W-1:0] mode,
    output logic              halt_flag,
    output logic              rst_flag,
    output logic              tx_en,
    output logic              rx_en
);

    logic run;

    assign tx_en = run;
    assign rx_en = run;

    always_comb begin
        mode      = MODE_RESET;
        halt_flag = 1'b0;
        rst_flag  = 1'b0;
        run       = 1'b0;
        unique case (state)
            ST_RESET: begin
                mode     = MODE_RESET;
                rst_flag = 1'b1;
            end
            ST_NORMAL: begin
                mode = MODE_NORMAL;
                run  = 1'b1;
            end
            ST_HALT_REQ: begin
                mode = MODE_HALT_REQ;
                run  = 1'b1;
            end
            ST_WAKE_HALT: begin
                mode = MODE_HALT_REQ;
            end
            ST_HALT: begin
                mode      = MODE_HALT;
                halt_flag = 1'b1;
            end
            ST_SLEEP: begin
                mode = MODE_SLEEP;
            end
            default: begin
                mode     = MODE_RESET;
                rst_flag = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              ctrl_rst_req,
    input  logic              ctrl_halt_req,
    input  logic              ctrl_sleep,
    input  logic              ctrl_halt_boff,
    input  logic              ctrl_auto_wake,
    input  logic              ctrl_auto_halt,
    input  logic              tx_busy,
    input  logic              rx_busy,
    input  logic              bus_off,
    input  logic              bus_dominant,
    output logic              halt_flag,
    output logic              rst_flag,
    output logic [MODE_W-1:0] mode,
    output logic              tx_en,
    output logic              rx_en
);

    ctrl_t wdata;
    ctrl_t ctrl_q;
    st_e   state;

    assign wdata = '{
        rst_req:   ctrl_rst_req,
        halt_req:  ctrl_halt_req,
        sleep:     ctrl_sleep,
        halt_boff: ctrl_halt_boff,
        auto_wake: ctrl_auto_wake,
        auto_halt: ctrl_auto_halt
    };

    can_mode_ctrl_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (ctrl_we),
        .wdata        (wdata),
        .state        (state),
        .bus_off      (bus_off),
        .bus_dominant (bus_dominant),
        .q            (ctrl_q)
    );

    can_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (ctrl_q.rst_req),
        .halt_req  (ctrl_q.halt_req),
        .sleep     (ctrl_q.sleep),
        .halt_boff (ctrl_q.halt_boff),
        .tx_busy   (tx_busy),
        .rx_busy   (rx_busy),
        .bus_off   (bus_off),
        .state     (state)
    );

    can_mode_out u_out (
        .state     (state),
        .mode      (mode),
        .halt_flag (halt_flag),
        .rst_flag  (rst_flag),
        .tx_en     (tx_en),
        .rx_en     (rx_en)
    );

endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       tx_en,
    input logic       rx_en,
    input logic       halt_flag,
    input logic       tx_busy,
    input logic       rx_busy,
    input logic       bus_off,
    input logic       halt_boff,
    input logic       rst_req
);

    // R4: busy traffic or bus-off blocks halt entry when the bypass is off
    p_busy_blocks_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && tx_en && !halt_boff && !rst_req && (tx_busy || rx_busy || bus_off))
        |=> mode != 3'd3);

    // R6: halt means the engine is off
    p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_flag |-> (!tx_en && !rx_en && mode == 3'd3));

    // R9: sleep is only entered from halt
    p_sleep_from_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && $past(mode) != 3'd4) |-> $past(mode) == 3'd3);

    // R11: halt request with engine off goes straight to halt
    p_wake_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd2 && !tx_en && !rst_req) |=> mode == 3'd3);

    // R13: a stored reset request forces reset mode
    p_rst_forces_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (mode == 3'd0));

endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .halt_flag (halt_flag),
    .tx_busy   (tx_busy),
    .rx_busy   (rx_busy),
    .bus_off   (bus_off),
    .halt_boff (ctrl_q.halt_boff),
    .rst_req   (ctrl_q.rst_req)
);

// File: tb/can_mode_seq_tb.sv
`timescale 1ns/1ps
module can_mode_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic       ctrl_rst_req = 1'b0;
    logic       ctrl_halt_req = 1'b0;
    logic       ctrl_sleep = 1'b0;
    logic       ctrl_halt_boff = 1'b0;
    logic       ctrl_auto_wake = 1'b0;
    logic       ctrl_auto_halt = 1'b0;
    logic       tx_busy = 1'b0;
    logic       rx_busy = 1'b0;
    logic       bus_off = 1'b0;
    logic       bus_dominant = 1'b0;
    logic       halt_flag;
    logic       rst_flag;
    logic [2:0] mode;
    logic       tx_en;
    logic       rx_en;

    logic cfg_hb = 1'b0;
    logic cfg_aw = 1'b0;
    logic cfg_ah = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    can_mode_seq u_dut (
        .clk (clk), .rst_n (rst_n), .ctrl_we (ctrl_we),
        .ctrl_rst_req (ctrl_rst_req), .ctrl_halt_req (ctrl_halt_req),
        .ctrl_sleep (ctrl_sleep), .ctrl_halt_boff (ctrl_halt_boff),
        .ctrl_auto_wake (ctrl_auto_wake), .ctrl_auto_halt (ctrl_auto_halt),
        .tx_busy (tx_busy), .rx_busy (rx_busy), .bus_off (bus_off),
        .bus_dominant (bus_dominant), .halt_flag (halt_flag),
        .rst_flag (rst_flag), .mode (mode), .tx_en (tx_en), .rx_en (rx_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // outputs packed: {mode, halt_flag, rst_flag, tx_en, rx_en}
    function automatic int outs();
        return {mode, halt_flag, rst_flag, tx_en, rx_en};
    endfunction

    function automatic int expo(input int m);
        int run;
        run = (m == 1 || m == 2) ? 1 : 0;
        return (m << 4) | ((m == 3 ? 1 : 0) << 3) | ((m == 0 ? 1 : 0) << 2) | (run << 1) | run;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic r, input logic h, input logic s);
        ctrl_we        = 1'b1;
        ctrl_rst_req   = r;
        ctrl_halt_req  = h;
        ctrl_sleep     = s;
        ctrl_halt_boff = cfg_hb;
        ctrl_auto_wake = cfg_aw;
        ctrl_auto_halt = cfg_ah;
        step(1);
        ctrl_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic goto_halt();
        tx_busy = 0; rx_busy = 0; bus_off = 0;
        wr(0, 1, 0); step(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reset outputs", outs(), expo(0));
        step(3);
        chk("R1 reset held while request set", outs(), expo(0));

        wr(0, 0, 0); step(1);
        chk("R2 leave reset to normal", outs(), expo(1));

        // halt entry sweep over busy/bus-off and the bypass enable
        for (int hb = 0; hb < 2; hb++) begin
            for (int c = 0; c < 8; c++) begin
                int t, r, b, go;
                t = c & 1; r = (c >> 1) & 1; b = (c >> 2) & 1;
                go = hb ? (b | ((t | r) == 0)) : ((t | r | b) == 0);
                cfg_hb = hb[0];
                tx_busy = t[0]; rx_busy = r[0]; bus_off = b[0];
                wr(0, 1, 0); step(1);
                chk("R3 halt request state", outs(), expo(2));
                step(1);
                chk(hb ? "R5 halt entry with bypass" : "R4 halt entry strict", outs(), expo(go ? 3 : 2));
                if (!go) begin
                    wr(0, 0, 0); step(2);
                    chk("R7 halt request drop ignored", outs(), expo(2));
                    tx_busy = 0; rx_busy = 0; bus_off = 0;
                    step(1);
                    chk("R7 halt reached after drop", outs(), expo(3));
                end
                tx_busy = 0; rx_busy = 0; bus_off = 0;
                chk("R6 halt flag and enables", outs(), expo(3));
                wr(0, 0, 0); step(1);
                chk("R8 resume to normal", outs(), expo(1));
            end
        end
        cfg_hb = 0;

        // sleep entry rules
        wr(0, 0, 1); step(2);
        chk("R9 sleep write in normal ignored", outs(), expo(1));
        goto_halt();
        chk("R6 halt before sleep", outs(), expo(3));
        wr(0, 1, 1); step(2);
        chk("R9 sleep with halt kept ignored", outs(), expo(3));
        wr(0, 0, 1); step(1);
        chk("R9 sleep entered", outs(), expo(4));
        step(3);
        chk("R9 sleep held", outs(), expo(4));

        // wake paths
        bus_dominant = 1; step(3); bus_dominant = 0;
        chk("R10 dominant ignored without auto-wake", outs(), expo(4));
        wr(0, 0, 0); step(1);
        chk("R10 software wake to normal", outs(), expo(1));

        cfg_aw = 1;
        goto_halt();
        wr(0, 0, 1); step(1);
        chk("R10 sleep again", outs(), expo(4));
        bus_dominant = 1; step(1); bus_dominant = 0; step(1);
        chk("R10 auto-wake on dominant", outs(), expo(1));
        cfg_aw = 0;

        goto_halt();
        wr(0, 0, 1); step(1);
        tx_busy = 1; rx_busy = 1; bus_off = 1;
        wr(0, 1, 0); step(1);
        chk("R11 wake into halt request, engine off", outs(), (2 << 4));
        step(1);
        chk("R11 halt after wake", outs(), expo(3));
        tx_busy = 0; rx_busy = 0; bus_off = 0;
        wr(0, 0, 0); step(1);
        chk("R8 resume after wake halt", outs(), expo(1));

        // automatic halt on bus-off under all enable pairs
        for (int e = 0; e < 4; e++) begin
            cfg_ah = e[0]; cfg_hb = e[1];
            wr(0, 0, 0); step(2);
            bus_off = 1; step(3);
            chk("R12 bus-off auto halt", outs(), expo(e == 3 ? 3 : 1));
            bus_off = 0; step(1);
            if (e == 3) begin
                wr(0, 0, 0); step(1);
                chk("R12 resume after auto halt", outs(), expo(1));
            end
        end
        cfg_ah = 0; cfg_hb = 0;

        // software reset from sleep
        goto_halt();
        wr(0, 0, 1); step(1);
        wr(1, 0, 0); step(1);
        chk("R13 reset request from sleep", outs(), expo(0));
        wr(0, 0, 0); step(1);
        chk("R13 sleep and halt bits cleared", outs(), expo(1));
        goto_halt();
        wr(1, 1, 0); step(1);
        chk("R13 reset request from halt", outs(), expo(0));
        wr(0, 0, 0); step(1);
        chk("R13 halt bit cleared by reset", outs(), expo(1));

        finish_run();
    end

endmodule